// File: doc/BRIEF.md
# Dual-Channel Converter Command Front End

This block is the digital side of a two-channel voltage-output converter. A host writes 16-bit command words over a write-only serial link made of a chip select, a clock and a data line. Each word names one channel. It also carries a code of `CODE_W` bits and three control bits: reference buffering, gain selection and channel activity. The whole block runs on one system clock. It oversamples the serial pins through synchronisers. It accepts data on the rising serial clock edge whichever idle level the clock has.

Each channel holds two stages. The input stage takes a command as soon as a complete frame ends. The output stage drives the analog side. An active-low latch input copies both input stages to both output stages in the same clock cycle, and keeps copying for as long as it is held low. An active-low hardware shutdown pin turns both channels off. The per-channel active bit turns one channel off when it is written as 0. After power-on reset both channels stay off until a command has been received and then transferred.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset both channels are off (`ch_on`=0), their codes are 0, gain is double (`ch_gain2x`=1) and the reference is unbuffered (`ch_ref_buf`=0).
- R2: A frame is 16 bits, MSB first. Bit 15 picks the channel (0 = A, 1 = B). Bit 14 is the buffer bit, bit 13 the gain bit and bit 12 the active bit. Bits 11..0 hold the code left-justified, and with the default `CODE_W`=12 all twelve bits are used. Only the selected channel is changed.
- R3: Data is taken on the rising serial clock edge. Frames sent with the clock idling low or idling high give the same result.
- R4: When chip select rises after a bit count other than 16, the frame is dropped and no input stage changes.
- R5: Clock and data activity while chip select is high has no effect.
- R6: While `latch_n` stays high, no output changes, even after new commands have been received.
- R7: While `latch_n` is low, both channels' output stages take their input stages in the same clock cycle.
- R8: With `latch_n` held low all the time, the outputs change only after chip select rises at the end of a valid frame.
- R9: Gain bit 1 selects unity gain (`ch_gain2x`=0) and 0 selects double gain. Buffer bit 1 selects buffered (`ch_ref_buf`=1).
- R10: A transferred command with active bit 0 turns its channel off. The channel comes back on only once a command with active bit 1 has been transferred.
- R11: `hw_shdn_n` low turns both channels off. Commands are still accepted while it is low. Raising it restores the state the output stages hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| latch_n | input | 1 | Active-low transfer of input stages to output stages |
| hw_shdn_n | input | 1 | Active-low shutdown of both channels |
| ch_code | output | 2*CODE_W | Output codes, channel A in the low half |
| ch_gain2x | output | 2 | Per channel: 1 = double gain |
| ch_ref_buf | output | 2 | Per channel: 1 = buffered reference |
| ch_on | output | 2 | Per channel: 1 = output enabled |

## Verification
Commands are sent with the serial clock idling low and idling high. Matching outputs show that sampling depends on the edge direction and not on the idle level. Frames of 15 and 17 bits, and clock toggling with chip select high, separate a receiver that checks the bit count from one that just keeps its last 16 bits. The bench notes the cycle in which each channel's code moves during a latch pulse, which shows whether the two channels transfer together. Holding the latch high, holding it low, and asserting hardware shutdown in the middle of a write separate the input stage from the output stage and from the enable path.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
   localparam int FRAME_BITS = 16;
   localparam int SEL_POS    = 15;
   localparam int RAW_CODE_W = 12;

   typedef struct packed {
      logic                  ref_buf;
      logic                  unity;
      logic                  active;
      logic [RAW_CODE_W-1:0] code;
   } chan_word_t;
endpackage

// File: rtl/sync_cell.sv
module sync_cell #(
   parameter int              WIDTH     = 1,
   parameter int              STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sync_cell: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RESET_VAL;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
   parameter int NBITS = dacif_pkg::FRAME_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csn_s,
   input  logic             sck_s,
   input  logic             sdi_s,
   output logic             stb,
   output logic [NBITS-1:0] word
);
   localparam int CNT_W = $clog2(NBITS) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(NBITS);

   generate
      if (NBITS < 2) begin : g_bad_len
         $error("frame_rx: NBITS too small");
      end
   endgenerate

   logic             sck_q, csn_q;
   logic [CNT_W-1:0] cnt;
   logic [NBITS-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
         cnt   <= '0;
         shreg <= '0;
         stb   <= 1'b0;
         word  <= '0;
      end else begin
         sck_q <= sck_s;
         csn_q <= csn_s;
         stb   <= 1'b0;
         if (csn_s) begin
            cnt <= '0;
            if (!csn_q && cnt == CNT_GOOD) begin
               stb  <= 1'b1;
               word <= shreg;
            end
         end else if (sck_s && !sck_q) begin
            shreg <= {shreg[NBITS-2:0], sdi_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
      end
   end

   // R5: bit counter stays cleared while the select line is idle
   assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && csn_q) |-> (cnt == '0));
   // R4: a frame is only committed once chip select has gone high
   assert_commit_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> csn_s);
endmodule

// File: rtl/chan_bank.sv
module chan_bank
   import dacif_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  chan_word_t        wr_word,
   input  logic              xfer,
   input  logic              hw_ok,
   output logic [CODE_W-1:0] code_o,
   output logic              gain2x_o,
   output logic              ref_buf_o,
   output logic              on_o
);
   localparam chan_word_t RST_WORD = '{ref_buf: 1'b0, unity: 1'b0, active: 1'b0, code: '0};

   chan_word_t in_q, out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= RST_WORD;
         out_q <= RST_WORD;
         on_o  <= 1'b0;
      end else begin
         if (load) in_q  <= wr_word;
         if (xfer) out_q <= in_q;
         on_o <= out_q.active & hw_ok;
      end
   end

   assign code_o    = out_q.code[RAW_CODE_W-1 -: CODE_W];
   assign gain2x_o  = ~out_q.unity;
   assign ref_buf_o = out_q.ref_buf;

   // R4: input stage only moves on a committed frame for this channel
   assert_input_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(in_q));
   // R6: output stage only moves while the transfer is asserted
   assert_output_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(out_q));
   // R11: hardware shutdown forces the enable low one cycle later
   assert_hw_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_ok |=> !on_o);
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
   import dacif_pkg::*;
#(
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_csn,
   input  logic                spi_sck,
   input  logic                spi_sdi,
   input  logic                latch_n,
   input  logic                hw_shdn_n,
   output logic [2*CODE_W-1:0] ch_code,
   output logic [1:0]          ch_gain2x,
   output logic [1:0]          ch_ref_buf,
   output logic [1:0]          ch_on
);
   localparam int NCH = 2;

   generate
      if (CODE_W != 8 && CODE_W != 10 && CODE_W != 12) begin : g_bad_code
         $error("dual_dac_frontend: CODE_W must be 8, 10 or 12");
      end
   endgenerate

   logic                  csn_s, sck_s, sdi_s, latch_n_s, hw_ok_s;
   logic                  stb;
   logic [FRAME_BITS-1:0] word;
   chan_word_t            wr_word;

   sync_cell #(.WIDTH(5), .STAGES(SYNC_STAGES), .RESET_VAL(5'b10011)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_csn, spi_sck, spi_sdi, latch_n, hw_shdn_n}),
      .q     ({csn_s, sck_s, sdi_s, latch_n_s, hw_ok_s})
   );

   frame_rx #(.NBITS(FRAME_BITS)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .csn_s (csn_s),
      .sck_s (sck_s),
      .sdi_s (sdi_s),
      .stb   (stb),
      .word  (word)
   );

   assign wr_word = chan_word_t'(word[SEL_POS-1:0]);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         chan_bank #(.CODE_W(CODE_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (stb && (word[SEL_POS] == 1'(i))),
            .wr_word   (wr_word),
            .xfer      (!latch_n_s),
            .hw_ok     (hw_ok_s),
            .code_o    (ch_code[i*CODE_W +: CODE_W]),
            .gain2x_o  (ch_gain2x[i]),
            .ref_buf_o (ch_ref_buf[i]),
            .on_o      (ch_on[i])
         );
      end
   endgenerate

   // R7: both channels share one transfer, so their codes never move apart while latch is high
   assert_joint_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      latch_n_s |=> $stable(ch_code));
endmodule

// File: tb/sim_dual_dac_frontend.sv
`timescale 1ns/1ps
module sim_dual_dac_frontend;
   localparam int W = 12;
   localparam int H = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_csn = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
   logic latch_n = 1'b1, hw_shdn_n = 1'b1;
   logic [2*W-1:0] ch_code;
   logic [1:0] ch_gain2x, ch_ref_buf, ch_on;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   dual_dac_frontend #(.CODE_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
      .latch_n(latch_n), .hw_shdn_n(hw_shdn_n), .ch_code(ch_code), .ch_gain2x(ch_gain2x),
      .ch_ref_buf(ch_ref_buf), .ch_on(ch_on)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_bits(input logic [31:0] data, input int nbits, input bit idle_high);
      spi_sck = idle_high;
      tick(H);
      spi_csn = 1'b0;
      tick(H);
      for (int b = nbits - 1; b >= 0; b--) begin
         spi_sck = 1'b0;
         spi_sdi = data[b];
         tick(H);
         spi_sck = 1'b1;
         tick(H);
         if (!idle_high) spi_sck = 1'b0;
      end
      tick(H);
   endtask

   task automatic spi_send(input logic [31:0] data, input int nbits, input bit idle_high);
      spi_bits(data, nbits, idle_high);
      spi_csn = 1'b1;
      tick(8);
   endtask

   task automatic pulse_latch();
      latch_n = 1'b0;
      tick(4);
      latch_n = 1'b1;
      tick(6);
   endtask

   task automatic t_reset();
      check("R1 code", ch_code, 0);
      check("R1 gain", ch_gain2x, 2'b11);
      check("R1 buf", ch_ref_buf, 2'b00);
      check("R1 on", ch_on, 2'b00);
   endtask

   task automatic t_hold_then_latch();
      spi_send(32'h3ABC, 16, 1'b0);
      check("R6 code held", ch_code, 0);
      check("R6 on held", ch_on, 2'b00);
      pulse_latch();
      check("R2 codeA", ch_code[W-1:0], 12'hABC);
      check("R2 codeB untouched", ch_code[2*W-1:W], 0);
      check("R9 unity gain A", ch_gain2x, 2'b10);
      check("R9 unbuffered A", ch_ref_buf, 2'b00);
      check("R2 onA", ch_on, 2'b01);
   endtask

   task automatic t_both_simul();
      int ca = -1;
      int cb = -1;
      spi_send(32'h5123, 16, 1'b0);
      spi_send(32'hD456, 16, 1'b1);
      check("R6 unchanged before latch", ch_code, {12'h000, 12'hABC});
      latch_n = 1'b0;
      for (int c = 0; c < 12; c++) begin
         tick(1);
         if (ca < 0 && ch_code[W-1:0] == 12'h123) ca = c;
         if (cb < 0 && ch_code[2*W-1:W] == 12'h456) cb = c;
      end
      latch_n = 1'b1;
      tick(6);
      check("R7 same cycle", 32'(ca), 32'(cb));
      check("R3 idle-high frame on B", ch_code[2*W-1:W], 12'h456);
      check("R9 double gain", ch_gain2x, 2'b11);
      check("R9 buffered", ch_ref_buf, 2'b11);
      check("R2 both on", ch_on, 2'b11);
   endtask

   task automatic t_bad_len();
      spi_send(32'h7FFF, 15, 1'b0);
      spi_send(32'h1FFFF, 17, 1'b1);
      pulse_latch();
      check("R4 short/long dropped", ch_code[W-1:0], 12'h123);
      check("R4 settings kept", ch_gain2x, 2'b11);
   endtask

   task automatic t_cs_high();
      for (int k = 0; k < 20; k++) begin
         spi_sdi = k[0];
         spi_sck = 1'b1;
         tick(H);
         spi_sck = 1'b0;
         tick(H);
      end
      pulse_latch();
      check("R5 no effect", ch_code, {12'h456, 12'h123});
      spi_send(32'h1777, 16, 1'b0);
      pulse_latch();
      check("R5 next frame clean", ch_code[W-1:0], 12'h777);
   endtask

   task automatic t_soft_shdn();
      spi_send(32'h8456, 16, 1'b0);
      pulse_latch();
      check("R10 B off", ch_on, 2'b01);
      spi_send(32'h9321, 16, 1'b0);
      tick(10);
      check("R10 stays off before latch", ch_on, 2'b01);
      pulse_latch();
      check("R10 B back on", ch_on, 2'b11);
      check("R10 B code", ch_code[2*W-1:W], 12'h321);
   endtask

   task automatic t_hw_shdn();
      hw_shdn_n = 1'b0;
      tick(6);
      check("R11 both off", ch_on, 2'b00);
      spi_send(32'h10AA, 16, 1'b1);
      pulse_latch();
      check("R11 still off", ch_on, 2'b00);
      check("R11 write accepted", ch_code[W-1:0], 12'h0AA);
      hw_shdn_n = 1'b1;
      tick(6);
      check("R11 restored", ch_on, 2'b11);
   endtask

   task automatic t_latch_tied();
      latch_n = 1'b0;
      tick(6);
      spi_bits(32'h1555, 16, 1'b0);
      tick(6);
      check("R8 no change before CS rise", ch_code[W-1:0], 12'h0AA);
      spi_csn = 1'b1;
      tick(10);
      check("R8 updated after CS rise", ch_code[W-1:0], 12'h555);
      latch_n = 1'b1;
      tick(4);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_hold_then_latch();
      t_both_simul();
      t_bad_len();
      t_cs_high();
      t_soft_shdn();
      t_hw_shdn();
      t_latch_tied();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule